// File: doc/BRIEF.md
# Cache Tag Invalidation Sequencer

This block clears the whole tag store of a set-associative cache when software asks for it. A write to a small control/status word starts a walk. The walk visits every way of every set, one entry per clock. For each entry it drops the valid and lock flags and rewrites the stored parity bit so that it matches the stored tag. While the walk runs the cache reports busy: ordinary lookups are stalled and never hit, and tag installs are ignored. Snoop lookups are still answered, and a snoop takes the tag store for its cycle, so the walker waits during that cycle.

An interrupt request line from the interrupt controller ends a running walk on the next edge. This happens whatever the core's own interrupt mask says. When it does, the hardware sets a sticky abort flag, and only a software write of 0 clears that flag. Entries already visited stay invalid and the rest keep their old contents. The same word also holds a cache-enable bit, which gates ordinary hits, and a write-policy bit that is stored and read back.

The walker is a four-state machine. IDLE goes to PREP on an accepted start. PREP goes to WALK after one cycle and clears the entry index. WALK advances the index on each cycle without a snoop and goes to FINISH after the last entry. FINISH goes back to IDLE. From PREP, WALK or FINISH, an interrupt request forces the machine to IDLE (the abort transition) and no entry is written on that edge.

Top module: `cache_inval_seq`

## Requirements
- R1: The control word has CE at bit 0 (read/write), WM at bit 1 (0 = write-through, 1 = copyback), INV at bit 2 and ABT at bit 3. After reset the word reads 0, and reset does not start a walk.
- R2: Writing INV=1 while idle starts a walk. INV reads 1 until the walk ends and then clears by itself. A walk with no snoops and no abort keeps INV at 1 for exactly SETS*WAYS+2 cycles.
- R3: Every entry the walk visits ends with valid=0 and lock=0, and its parity bit equals the XOR of its tag bits. snp_perr is 1 when any way of the snooped set holds a parity bit that differs from the XOR of its tag.
- R4: While INV reads 1, req_stall equals req_valid, req_hit is 0, and tag installs are ignored.
- R5: A snoop is answered during a walk. Each WALK cycle that carries a snoop adds one cycle to the walk.
- R6: An asserted irq_req in any busy cycle ends the walk at the next edge. INV clears and ABT sets on that same edge. Entries visited before that edge stay invalid, and unvisited entries keep their contents.
- R7: ABT is set only by an abort. A write with bit 3 = 0 clears it, and a write with bit 3 = 1 leaves it unchanged. If an abort and a clearing write fall on the same edge, ABT ends at 1.
- R8: A write of INV=1 during a walk is ignored and does not change the walk length.
- R9: The walk behaves the same with CE=0 or CE=1. req_hit is 1 only when CE=1, the block is idle, and a valid way of req_set holds req_tag.
- R10: irq_req asserted while idle changes nothing in the control word.
- R11: An install while idle writes ins_tag, ins_lock and ins_par into the chosen entry and sets its valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 4 | Control word write data |
| csr_rdata | output | 4 | Control word read value {ABT, INV, WM, CE} |
| irq_req | input | 1 | Interrupt request from the interrupt controller |
| req_valid | input | 1 | Ordinary lookup valid |
| req_set | input | $clog2(SETS) | Ordinary lookup set index |
| req_tag | input | TAG_W | Ordinary lookup tag |
| req_stall | output | 1 | Ordinary lookup stalled |
| req_hit | output | 1 | Ordinary lookup hit |
| ins_valid | input | 1 | Tag install strobe |
| ins_set | input | $clog2(SETS) | Install set index |
| ins_way | input | $clog2(WAYS) | Install way |
| ins_tag | input | TAG_W | Install tag |
| ins_lock | input | 1 | Install lock flag |
| ins_par | input | 1 | Install parity bit (stored as given) |
| snp_valid | input | 1 | Snoop lookup valid |
| snp_set | input | $clog2(SETS) | Snoop set index |
| snp_tag | input | TAG_W | Snoop tag |
| snp_hit | output | 1 | Snoop hit |
| snp_lock | output | 1 | Lock flag of the hit way |
| snp_perr | output | 1 | Parity mismatch in the snooped set |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a snoop and a walker step meet: the bench drives snoops in the middle of a walk and requires the right hit and lock answers from a set the walker has not reached yet, and a walk that is longer by one cycle for each snoop. In the second, a hardware abort and a software write that clears ABT land on the same edge: the bench drives both at once and requires ABT to read 1 afterwards.

// File: rtl/cinv_pkg.sv
package cinv_pkg;
    localparam int CW_BITS = 4;
    localparam int BIT_CE  = 0;
    localparam int BIT_WM  = 1;
    localparam int BIT_INV = 2;
    localparam int BIT_ABT = 3;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_PREP,
        WK_WALK,
        WK_FINISH
    } wk_state_e;
endpackage

// File: rtl/cinv_ctl_regs.sv
module cinv_ctl_regs
    import cinv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [CW_BITS-1:0] wdata,
    input  logic               abort,
    input  logic               busy,
    output logic               start,
    output logic               ce,
    output logic [CW_BITS-1:0] rdata
);
    logic wm_q, abt_q, ce_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q  <= 1'b0;
            wm_q  <= 1'b0;
            abt_q <= 1'b0;
        end else begin
            if (wr) begin
                ce_q <= wdata[BIT_CE];
                wm_q <= wdata[BIT_WM];
                if (!wdata[BIT_ABT]) abt_q <= 1'b0;
            end
            if (abort) abt_q <= 1'b1;
        end
    end

    always_comb begin
        start          = wr && wdata[BIT_INV] && !busy;
        ce             = ce_q;
        rdata          = '0;
        rdata[BIT_CE]  = ce_q;
        rdata[BIT_WM]  = wm_q;
        rdata[BIT_INV] = busy;
        rdata[BIT_ABT] = abt_q;
    end

    // R7: the flag survives every edge that carries no clearing write
    assert_abt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abt_q && !(wr && !wdata[BIT_ABT]) |=> abt_q);
    // R7: only an abort can raise the flag
    assert_abt_hw_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !abt_q && !abort |=> !abt_q);
endmodule

// File: rtl/cinv_walker.sv
module cinv_walker
    import cinv_pkg::*;
#(
    parameter int SETS = 32,
    parameter int WAYS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    irq,
    input  logic                    snp_hold,
    output logic                    busy,
    output logic                    abort,
    output logic                    wr_en,
    output logic [$clog2(SETS)-1:0] wr_set,
    output logic [$clog2(WAYS)-1:0] wr_way
);
    localparam int ENTRIES = SETS * WAYS;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int WAY_W   = $clog2(WAYS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    wk_state_e        st, st_nxt;
    logic [IDX_W-1:0] idx, idx_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= WK_IDLE;
            idx <= '0;
        end else begin
            st  <= st_nxt;
            idx <= idx_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        idx_nxt = idx;
        unique case (st)
            WK_IDLE:   if (start) st_nxt = WK_PREP;
            WK_PREP: begin
                st_nxt  = WK_WALK;
                idx_nxt = '0;
            end
            WK_WALK: begin
                if (!snp_hold) begin
                    idx_nxt = idx + IDX_W'(1);
                    if (idx == LAST) st_nxt = WK_FINISH;
                end
            end
            WK_FINISH: st_nxt = WK_IDLE;
            default:   st_nxt = WK_IDLE;
        endcase
        if (st != WK_IDLE && irq) st_nxt = WK_IDLE;
    end

    always_comb begin
        busy   = (st != WK_IDLE);
        abort  = busy && irq;
        wr_en  = (st == WK_WALK) && !snp_hold && !irq;
        wr_set = idx[IDX_W-1:WAY_W];
        wr_way = idx[WAY_W-1:0];
    end

    // R6: an interrupt request ends any running walk on the next edge
    assert_abort_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && irq |=> !busy);
    // R5: a snoop cycle never carries a walker write
    assert_snoop_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !snp_hold);
    // R3: back-to-back writes visit consecutive entries
    assert_walk_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> idx == IDX_W'($past(idx) + IDX_W'(1)));
endmodule

// File: rtl/cinv_tag_store.sv
module cinv_tag_store #(
    parameter int SETS  = 32,
    parameter int WAYS  = 4,
    parameter int TAG_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wk_we,
    input  logic [$clog2(SETS)-1:0]       wk_set,
    input  logic [$clog2(WAYS)-1:0]       wk_way,
    input  logic                          ins_we,
    input  logic [$clog2(SETS)-1:0]       ins_set,
    input  logic [$clog2(WAYS)-1:0]       ins_way,
    input  logic [TAG_W-1:0]              ins_tag,
    input  logic                          ins_lock,
    input  logic                          ins_par,
    input  logic [1:0][$clog2(SETS)-1:0]  lk_set,
    input  logic [1:0][TAG_W-1:0]         lk_tag,
    output logic [1:0]                    lk_hit,
    output logic [1:0]                    lk_lock,
    output logic [1:0]                    lk_perr
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic             vld_q [SETS][WAYS];
    logic             lck_q [SETS][WAYS];
    logic             par_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (wk_we) begin
            vld_q[wk_set][wk_way] <= 1'b0;
            lck_q[wk_set][wk_way] <= 1'b0;
            par_q[wk_set][wk_way] <= ^tag_q[wk_set][wk_way];
        end else if (ins_we) begin
            tag_q[ins_set][ins_way] <= ins_tag;
            vld_q[ins_set][ins_way] <= 1'b1;
            lck_q[ins_set][ins_way] <= ins_lock;
            par_q[ins_set][ins_way] <= ins_par;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_port
        logic h, l, e;
        always_comb begin
            h = 1'b0;
            l = 1'b0;
            e = 1'b0;
            for (int w = 0; w < WAYS; w++) begin
                if (vld_q[lk_set[p]][w] && tag_q[lk_set[p]][w] == lk_tag[p]) begin
                    h = 1'b1;
                    l = l | lck_q[lk_set[p]][w];
                end
                if (par_q[lk_set[p]][w] != ^tag_q[lk_set[p]][w]) e = 1'b1;
            end
        end
        assign lk_hit[p]  = h;
        assign lk_lock[p] = l;
        assign lk_perr[p] = e;
    end

    // R4: the walker and an install never write in the same cycle
    assert_one_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wk_we && ins_we));
endmodule

// File: rtl/cache_inval_seq.sv
module cache_inval_seq
    import cinv_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int WAYS  = 4,
    parameter int TAG_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csr_wr,
    input  logic [3:0]              csr_wdata,
    output logic [3:0]              csr_rdata,
    input  logic                    irq_req,
    input  logic                    req_valid,
    input  logic [$clog2(SETS)-1:0] req_set,
    input  logic [TAG_W-1:0]        req_tag,
    output logic                    req_stall,
    output logic                    req_hit,
    input  logic                    ins_valid,
    input  logic [$clog2(SETS)-1:0] ins_set,
    input  logic [$clog2(WAYS)-1:0] ins_way,
    input  logic [TAG_W-1:0]        ins_tag,
    input  logic                    ins_lock,
    input  logic                    ins_par,
    input  logic                    snp_valid,
    input  logic [$clog2(SETS)-1:0] snp_set,
    input  logic [TAG_W-1:0]        snp_tag,
    output logic                    snp_hit,
    output logic                    snp_lock,
    output logic                    snp_perr
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic             start, busy, abort, ce;
    logic             wk_we;
    logic [SET_W-1:0] wk_set;
    logic [WAY_W-1:0] wk_way;
    logic             ins_we;
    logic [1:0][SET_W-1:0] lk_set;
    logic [1:0][TAG_W-1:0] lk_tag;
    logic [1:0]       lk_hit, lk_lock, lk_perr;

    cinv_ctl_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (csr_wr),
        .wdata (csr_wdata),
        .abort (abort),
        .busy  (busy),
        .start (start),
        .ce    (ce),
        .rdata (csr_rdata)
    );

    cinv_walker #(.SETS(SETS), .WAYS(WAYS)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .irq      (irq_req),
        .snp_hold (snp_valid),
        .busy     (busy),
        .abort    (abort),
        .wr_en    (wk_we),
        .wr_set   (wk_set),
        .wr_way   (wk_way)
    );

    assign ins_we = ins_valid && !busy;
    assign lk_set = {snp_set, req_set};
    assign lk_tag = {snp_tag, req_tag};

    cinv_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wk_we    (wk_we),
        .wk_set   (wk_set),
        .wk_way   (wk_way),
        .ins_we   (ins_we),
        .ins_set  (ins_set),
        .ins_way  (ins_way),
        .ins_tag  (ins_tag),
        .ins_lock (ins_lock),
        .ins_par  (ins_par),
        .lk_set   (lk_set),
        .lk_tag   (lk_tag),
        .lk_hit   (lk_hit),
        .lk_lock  (lk_lock),
        .lk_perr  (lk_perr)
    );

    always_comb begin
        req_stall = req_valid && busy;
        req_hit   = req_valid && !busy && ce && lk_hit[0];
        snp_hit   = snp_valid && lk_hit[1];
        snp_lock  = snp_valid && lk_lock[1];
        snp_perr  = snp_valid && lk_perr[1];
    end

    // R2: an accepted start makes the block busy on the next edge
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr && csr_wdata[BIT_INV] && !csr_rdata[BIT_INV] |=> csr_rdata[BIT_INV]);
endmodule

// File: tb/cache_inval_seq_test.sv
module cache_inval_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_wr = 1'b0;
    logic [3:0] csr_wdata = '0;
    logic [3:0] csr_rdata;
    logic       irq_req = 1'b0;
    logic       req_valid = 1'b0;
    logic [4:0] req_set = '0;
    logic [7:0] req_tag = '0;
    logic       req_stall, req_hit;
    logic       ins_valid = 1'b0;
    logic [4:0] ins_set = '0;
    logic [1:0] ins_way = '0;
    logic [7:0] ins_tag = '0;
    logic       ins_lock = 1'b0;
    logic       ins_par = 1'b0;
    logic       snp_valid = 1'b0;
    logic [4:0] snp_set = '0;
    logic [7:0] snp_tag = '0;
    logic       snp_hit, snp_lock, snp_perr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic  h;
        logic  l;
        logic  p;
        string rq;
    } snp_item_t;
    snp_item_t sb[$];

    always #4 clk = ~clk;

    cache_inval_seq uut (
        .clk(clk), .rst_n(rst_n),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .irq_req(irq_req),
        .req_valid(req_valid), .req_set(req_set), .req_tag(req_tag),
        .req_stall(req_stall), .req_hit(req_hit),
        .ins_valid(ins_valid), .ins_set(ins_set), .ins_way(ins_way),
        .ins_tag(ins_tag), .ins_lock(ins_lock), .ins_par(ins_par),
        .snp_valid(snp_valid), .snp_set(snp_set), .snp_tag(snp_tag),
        .snp_hit(snp_hit), .snp_lock(snp_lock), .snp_perr(snp_perr)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // monitor: pops expected snoop answers as the design produces them
    always @(negedge clk) begin
        if (snp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R5: actual unexpected snoop expected none queued");
            end else begin
                snp_item_t it;
                it = sb.pop_front();
                if ({snp_hit, snp_lock, snp_perr} !== {it.h, it.l, it.p}) begin
                    errors++;
                    $display("FAIL %s: actual hit/lock/perr %b%b%b expected %b%b%b",
                             it.rq, snp_hit, snp_lock, snp_perr, it.h, it.l, it.p);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL R2: watchdog actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic csr_write(logic [3:0] d);
        @(posedge clk); #1;
        csr_wr = 1'b1; csr_wdata = d;
        @(posedge clk); #1;
        csr_wr = 1'b0;
    endtask

    task automatic install(logic [4:0] s, logic [1:0] w, logic [7:0] t, logic lk, logic pr);
        @(posedge clk); #1;
        ins_valid = 1'b1; ins_set = s; ins_way = w; ins_tag = t; ins_lock = lk; ins_par = pr;
        @(posedge clk); #1;
        ins_valid = 1'b0;
    endtask

    // driver: pushes the expected answer and presents the snoop
    task automatic snoop(logic [4:0] s, logic [7:0] t, logic eh, logic el, logic ep, string rq);
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_set = s; snp_tag = t;
        sb.push_back('{eh, el, ep, rq});
        @(posedge clk); #1;
        snp_valid = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        @(negedge clk);
        while (csr_rdata[2]) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", csr_rdata, 4'b0000);
        repeat (3) @(negedge clk);
        chk("R1 no walk after reset", csr_rdata[2], 1'b0);

        // R10: interrupt while idle
        irq_req = 1'b1;
        repeat (2) @(negedge clk);
        irq_req = 1'b0;
        @(negedge clk);
        chk("R10 idle irq ignored", csr_rdata, 4'b0000);

        // R2 / R9: full walk with CE=0
        csr_write(4'b0100);
        count_busy(n);
        chk("R2 walk length", n, 130);
        chk("R2 INV self-clears", csr_rdata, 4'b0000);
        snoop(5'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R9 set0 clean after CE=0 walk");
        snoop(5'd31, 8'h00, 1'b0, 1'b0, 1'b0, "R3 set31 clean");

        // R1 fields, R7 write 1 has no effect
        csr_write(4'b0011);
        @(negedge clk);
        chk("R1 CE/WM readback", csr_rdata, 4'b0011);
        csr_write(4'b1011);
        @(negedge clk);
        chk("R7 write 1 to ABT ignored", csr_rdata, 4'b0011);

        // R11 installs and R9 hit gating
        install(5'd3, 2'd1, 8'hA5, 1'b1, 1'b0);
        snoop(5'd3, 8'hA5, 1'b1, 1'b1, 1'b0, "R11 installed entry");
        @(negedge clk);
        req_valid = 1'b1; req_set = 5'd3; req_tag = 8'hA5;
        @(negedge clk);
        chk("R9 hit with CE=1", req_hit, 1'b1);
        req_valid = 1'b0;
        csr_write(4'b0010);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        chk("R9 no hit with CE=0", req_hit, 1'b0);
        req_valid = 1'b0;
        csr_write(4'b0011);

        // R3 parity repair setup
        install(5'd5, 2'd2, 8'h3C, 1'b0, 1'b1);
        snoop(5'd5, 8'h3C, 1'b1, 1'b0, 1'b1, "R3 bad parity seen");
        install(5'd31, 2'd3, 8'h77, 1'b1, 1'b0);

        // walk with snoops (R5), repeated start (R8), stalls and install (R4)
        csr_write(4'b0111);
        n = 0;
        @(negedge clk);
        while (csr_rdata[2]) begin
            n++;
            if (n >= 5 && n <= 7) begin
                snp_valid = 1'b1; snp_set = 5'd31; snp_tag = 8'h77;
                sb.push_back('{1'b1, 1'b1, 1'b0, "R5 snoop during walk"});
            end else snp_valid = 1'b0;
            if (n == 10) begin csr_wr = 1'b1; csr_wdata = 4'b0111; end
            if (n == 11) csr_wr = 1'b0;
            if (n == 20) begin req_valid = 1'b1; req_set = 5'd31; req_tag = 8'h77; end
            if (n == 21) begin
                chk("R4 stall while busy", req_stall, 1'b1);
                chk("R4 no hit while busy", req_hit, 1'b0);
                req_valid = 1'b0;
            end
            if (n == 100) begin
                ins_valid = 1'b1; ins_set = 5'd10; ins_way = 2'd0;
                ins_tag = 8'h5A; ins_lock = 1'b0; ins_par = 1'b0;
            end
            if (n == 101) ins_valid = 1'b0;
            @(negedge clk);
        end
        chk("R5 R8 walk length with 3 snoops", n, 133);
        chk("R2 word after walk", csr_rdata, 4'b0011);
        snoop(5'd31, 8'h77, 1'b0, 1'b0, 1'b0, "R3 locked entry cleared");
        snoop(5'd5, 8'h3C, 1'b0, 1'b0, 1'b0, "R3 parity rewritten");
        snoop(5'd10, 8'h5A, 1'b0, 1'b0, 1'b0, "R4 install during walk ignored");

        // R6 abort mid-walk
        install(5'd0, 2'd0, 8'h11, 1'b1, 1'b0);
        install(5'd31, 2'd3, 8'h77, 1'b1, 1'b0);
        csr_write(4'b0111);
        repeat (20) @(negedge clk);
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        chk("R6 abort word", csr_rdata, 4'b1011);
        snoop(5'd0, 8'h11, 1'b0, 1'b0, 1'b0, "R6 visited entry invalid");
        snoop(5'd31, 8'h77, 1'b1, 1'b1, 1'b0, "R6 unvisited entry kept");

        // R7 software clear
        csr_write(4'b0011);
        @(negedge clk);
        chk("R7 clear by writing 0", csr_rdata, 4'b0011);

        // R7 abort and clearing write on the same edge
        csr_write(4'b0111);
        repeat (5) @(negedge clk);
        csr_wr = 1'b1; csr_wdata = 4'b0011; irq_req = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0; irq_req = 1'b0;
        chk("R7 set wins over clear", csr_rdata, 4'b1011);
        csr_write(4'b0011);
        @(negedge clk);
        chk("R7 cleared afterwards", csr_rdata, 4'b0011);

        repeat (3) @(negedge clk);
        chk("R5 scoreboard drained", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule